// File: doc/BRIEF.md
# Scrolling Message Ticker

This block scrolls the word HELLO from right to left across eight seven-segment digits. Eight 3-bit character registers form a shift chain, and each register drives its own segment decoder. While the chain moves one position per step, a small load controller writes the message into the rightmost register, one character per step, for the first eight steps after reset. After that it closes the chain into a ring, so the leftmost character wraps around to the right edge and the text keeps circulating.

All flops run on the single system clock. A step is a one-cycle enable. It comes either from an internal prescaler that divides the fast clock by a parameter ratio (one second at 50 MHz by default) or from an external strobe, chosen by a mode input. Reset is synchronous and active-low.

Top module: `ticker_top`

## Requirements
- R1: While `rst_ni` is low at a clock edge, every digit takes the blank code (4) and the load sequence restarts at its first character. The prescaler count also returns to zero.
- R2: On every step each character moves one digit to the left: digit d+1 takes the old value of digit d. Digit 0 is the rightmost digit, and digit d sits at `chars_o[3d+2:3d]`.
- R3: On the first eight steps after reset, the rightmost digit receives H, E, L, L, O, blank, blank, blank in that order. The codes are H=0, E=1, L=2, O=3 and blank=4.
- R4: From the ninth step on, the rightmost digit receives the old leftmost character. After step n (n ≥ 8), the digit at position k counted from the left (k = 7 − d) holds message character (k + n) mod 8.
- R5: In a cycle without a step, the contents of every digit stay unchanged.
- R6: `seg_o[7d+6:7d]` is the active-low segment pattern of digit d, with bit 0 = a through bit 6 = g. The patterns are H = 7'h09, E = 7'h06, L = 7'h47, O = 7'h40 and blank = 7'h7F (all segments off).
- R7: With `use_ext_i` low, a step occurs once every `DIV` clock cycles. The first step falls on the `DIV`-th clock edge after reset is released.
- R8: With `use_ext_i` high, a step occurs in exactly those cycles in which `ext_step_i` is high, and the prescaler's ticks cause no step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| use_ext_i | input | 1 | 1: step on external strobe, 0: step on prescaler tick |
| ext_step_i | input | 1 | External one-cycle step strobe |
| chars_o | output | 3*DIGITS | Character code held by each digit |
| seg_o | output | 7*DIGITS | Active-low segment patterns, one field per digit |

## Verification
The bench builds the block with `DIV` = 4, so that several internal steps fit into a few dozen cycles. This lets the prescaler's step timing be checked edge by edge from the moment reset is released. In external-strobe mode the bench drives more than twenty steps with idle gaps between them. This covers the whole loading phase, the switch to the ring and several full rotations, and each step is compared digit by digit against an arithmetic model of the rotation. A reset in the middle of a run shows that loading restarts cleanly.

// File: rtl/ticker_pkg.sv
package ticker_pkg;
  localparam int CHAR_W = 3;
  localparam int SEG_W  = 7;
  localparam int MSG_LEN = 5;

  typedef enum logic [CHAR_W-1:0] {
    CH_H     = 3'd0,
    CH_E     = 3'd1,
    CH_L     = 3'd2,
    CH_O     = 3'd3,
    CH_BLANK = 3'd4
  } char_e;

  // message text, padded with blanks past MSG_LEN
  function automatic char_e msg_char(input int unsigned idx);
    case (idx)
      0:       msg_char = CH_H;
      1:       msg_char = CH_E;
      2, 3:    msg_char = CH_L;
      4:       msg_char = CH_O;
      default: msg_char = CH_BLANK;
    endcase
  endfunction

  // active-low, bit0 = a ... bit6 = g
  function automatic logic [SEG_W-1:0] seg_pattern(input logic [CHAR_W-1:0] c);
    case (c)
      CH_H:    seg_pattern = 7'h09;
      CH_E:    seg_pattern = 7'h06;
      CH_L:    seg_pattern = 7'h47;
      CH_O:    seg_pattern = 7'h40;
      default: seg_pattern = 7'h7F;
    endcase
  endfunction
endpackage

// File: rtl/ticker_prescaler.sv
module ticker_prescaler #(
  parameter int unsigned DIV = 50_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ticker_load_fsm.sv
module ticker_load_fsm
  import ticker_pkg::*;
#(
  parameter int unsigned DIGITS = 8
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  step_i,
  output logic  load_o,
  output char_e char_o
);
  localparam int unsigned IDX_W = (DIGITS > 2) ? $clog2(DIGITS) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DIGITS - 1);

  typedef enum logic {ST_LOAD, ST_RING} state_e;

  state_e           state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    if (step_i && state_q == ST_LOAD) begin
      if (idx_q == IDX_LAST) state_d = ST_RING;
      else                   idx_d   = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q <= ST_LOAD;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign load_o = (state_q == ST_LOAD);
  assign char_o = msg_char(32'(idx_q));
endmodule

// File: rtl/ticker_ring.sv
module ticker_ring
  import ticker_pkg::*;
#(
  parameter int unsigned DIGITS = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     step_i,
  input  logic                     load_i,
  input  char_e                    load_char_i,
  output logic [CHAR_W*DIGITS-1:0] chars_o
);
  char_e dig_q [DIGITS];

  // digit 0 is rightmost; characters travel toward higher indices
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int d = 0; d < DIGITS; d++) dig_q[d] <= CH_BLANK;
    end else if (step_i) begin
      for (int d = 1; d < DIGITS; d++) dig_q[d] <= dig_q[d-1];
      dig_q[0] <= load_i ? load_char_i : dig_q[DIGITS-1];
    end
  end

  for (genvar d = 0; d < DIGITS; d++) begin : g_out
    assign chars_o[d*CHAR_W +: CHAR_W] = dig_q[d];
  end
endmodule

// File: rtl/ticker_seg_dec.sv
module ticker_seg_dec
  import ticker_pkg::*;
(
  input  logic [CHAR_W-1:0] char_i,
  output logic [SEG_W-1:0]  seg_o
);
  assign seg_o = seg_pattern(char_i);
endmodule

// File: rtl/ticker_top.sv
module ticker_top
  import ticker_pkg::*;
#(
  parameter int unsigned DIGITS = 8,
  parameter int unsigned DIV    = 50_000_000
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      use_ext_i,
  input  logic                      ext_step_i,
  output logic [CHAR_W*DIGITS-1:0]  chars_o,
  output logic [SEG_W*DIGITS-1:0]   seg_o
);
  logic  tick;
  logic  step;
  logic  load;
  char_e load_char;

  ticker_prescaler #(.DIV(DIV)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  assign step = use_ext_i ? ext_step_i : tick;

  ticker_load_fsm #(.DIGITS(DIGITS)) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step),
    .load_o (load),
    .char_o (load_char)
  );

  ticker_ring #(.DIGITS(DIGITS)) u_ring (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step),
    .load_i      (load),
    .load_char_i (load_char),
    .chars_o     (chars_o)
  );

  for (genvar d = 0; d < DIGITS; d++) begin : g_dec
    ticker_seg_dec u_dec (
      .char_i (chars_o[d*CHAR_W +: CHAR_W]),
      .seg_o  (seg_o[d*SEG_W +: SEG_W])
    );
  end
endmodule

// File: rtl/ticker_checker.sv
module ticker_checker
  import ticker_pkg::*;
#(
  parameter int unsigned DIGITS = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     step_i,
  input logic                     load_i,
  input logic [CHAR_W*DIGITS-1:0] chars_i,
  input logic [SEG_W*DIGITS-1:0]  seg_i
);
  localparam int unsigned W = CHAR_W * DIGITS;

  p_reset_blank_r1: assert property (@(posedge clk_i)
    !rst_ni |=> chars_i == {DIGITS{CH_BLANK}});

  p_shift_left_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> chars_i[W-1:CHAR_W] == $past(chars_i[W-CHAR_W-1:0]));

  p_ring_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> chars_i[CHAR_W-1:0] == $past(chars_i[W-1:W-CHAR_W]));

  p_ring_stays_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> !load_i);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(chars_i));

  for (genvar d = 0; d < DIGITS; d++) begin : g_seg
    p_blank_dark_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chars_i[d*CHAR_W +: CHAR_W] == CH_BLANK |-> seg_i[d*SEG_W +: SEG_W] == 7'h7F);
    p_lit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chars_i[d*CHAR_W +: CHAR_W] < 3'd4 |-> seg_i[d*SEG_W +: SEG_W] != 7'h7F);
  end
endmodule

bind ticker_top ticker_checker #(.DIGITS(DIGITS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .step_i  (step),
  .load_i  (load),
  .chars_i (chars_o),
  .seg_i   (seg_o)
);

// File: tb/sim_ticker_top.sv
module sim_ticker_top;
  localparam int DIGITS = 8;
  localparam int DIV    = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic use_ext = 1'b1;
  logic ext_step = 1'b0;
  logic [3*DIGITS-1:0] chars;
  logic [7*DIGITS-1:0] seg;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ticker_top #(.DIGITS(DIGITS), .DIV(DIV)) u0 (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .use_ext_i  (use_ext),
    .ext_step_i (ext_step),
    .chars_o    (chars),
    .seg_o      (seg)
  );

  function automatic int msg(int i);
    case (i)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 2;
      4: return 3;
      default: return 4;
    endcase
  endfunction

  // expected code at output digit d (0 = rightmost) after n steps
  function automatic int exp_char(int n, int d);
    int k = DIGITS - 1 - d;
    if (n < DIGITS) return (k + n >= DIGITS) ? msg(k + n - DIGITS) : 4;
    return msg((k + n) % DIGITS);
  endfunction

  function automatic logic [6:0] exp_seg(int c);
    case (c)
      0: return 7'h09;
      1: return 7'h06;
      2: return 7'h47;
      3: return 7'h40;
      default: return 7'h7F;
    endcase
  endfunction

  task automatic check_all(int n, string tag);
    logic [3*DIGITS-1:0] ec;
    logic [7*DIGITS-1:0] es;
    for (int d = 0; d < DIGITS; d++) begin
      ec[d*3 +: 3] = 3'(exp_char(n, d));
      es[d*7 +: 7] = exp_seg(exp_char(n, d));
    end
    checks++;
    if (chars !== ec || seg !== es) begin
      failures++;
      $display("FAIL %s step=%0d chars=%h exp=%h seg=%h exp=%h (R2 R6)",
               tag, n, chars, ec, seg, es);
    end
  endtask

  task automatic do_reset(logic ext_mode);
    @(negedge clk);
    rst_ni = 1'b0;
    use_ext = ext_mode;
    ext_step = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic strobe();
    ext_step = 1'b1;
    @(negedge clk);
    ext_step = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    // R1: reset state
    do_reset(1'b1);
    check_all(0, "R1");
    // R8: prescaler ignored in external mode; R5 hold
    repeat (12) @(negedge clk);
    check_all(0, "R8");
    // R3 load, R4 ring, R2 shift, R5 hold between strobes
    n = 0;
    for (int i = 0; i < 26; i++) begin
      strobe();
      n++;
      check_all(n, (n <= DIGITS) ? "R3" : "R4");
      if (i % 5 == 2) begin
        repeat (3) @(negedge clk);
        check_all(n, "R5");
      end
    end
    // back-to-back strobes
    ext_step = 1'b1;
    repeat (3) begin
      @(negedge clk);
      n++;
      check_all(n, "R4");
    end
    ext_step = 1'b0;
    // R1: mid-run reset restarts loading
    do_reset(1'b1);
    check_all(0, "R1");
    for (int i = 1; i <= 3; i++) begin
      strobe();
      check_all(i, "R3");
    end
    // R7: internal prescaler, step every DIV edges
    do_reset(1'b0);
    check_all(0, "R7");
    for (int c = 1; c <= 44; c++) begin
      @(negedge clk);
      check_all(c / DIV, "R7");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule